// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block takes the individual interrupt conditions of a UART (receive line errors, receive FIFO fill against a programmable trigger level, character timeout, transmit holding empty, modem status change, received XOFF, and a rising edge on the CTS or RTS handshake line). From them it forms an identification byte and one interrupt request. The five classic sources are ranked at fixed priority, and only the highest pending one is encoded. The two flow-control events are kept as sticky flags beside the code.

A register-read strobe tells the block that software has read the identification byte. That read clears the flow-control flags. It also clears the transmit-empty event, but only if that event was the code shown at the time of the read. A holding-register write clears the transmit-empty event as well. Both outputs are registered, so each result appears one clock after the input cycle that causes it.

Identification byte layout: bit 0 is the active-low pending bit, bits 3:1 the source code, bit 4 the XOFF flag, bit 5 the flow-edge flag, bits 7:6 zero. Enable vector `ien`: bit 0 receive data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status, bit 4 XOFF flag, bit 5 flow-edge flag.

Top module: `uart_irq_id`

## Requirements
- R1: While `rst` is high, `iir` is 0x01 and `irq` is 0.
- R2: Bit 0 of `iir` is 0 exactly when an enabled coded source is pending; otherwise it is 1 and bits 3:1 are 000.
- R3: A line-status condition (any bit of `line_err`: overrun, parity, framing or break) with `ien[2]` set gives code 3, above all other sources.
- R4: The receive-data condition holds when `rx_count` is at least 1, 4, 8 or 14 for `rx_trig` 0, 1, 2 or 3. With `ien[0]` set it gives code 2, below line status.
- R5: `rx_timeout` gives code 6, below receive data and above transmit empty. Both code 2 and code 6 are masked by `ien[0]`.
- R6: A rise of `thr_empty` with `ien[1]` set gives code 1. The event is cleared by `thr_wr`, by `thr_empty` falling, or by an `iir_rd` in a cycle when `iir` shows code 1 with bit 0 low. A read while another code is shown leaves it pending.
- R7: `modem_delta` with `ien[3]` set gives code 0 with bit 0 low, the lowest rank.
- R8: A `xoff_seen` pulse sets `iir` bit 4, and `iir_rd` clears it. If both come in the same cycle, the set wins.
- R9: A `cts_rise` or `rts_rise` pulse sets `iir` bit 5, and `iir_rd` clears it.
- R10: `irq` is high when any enabled coded source is pending, or when bit 4 is set with `ien[4]`, or bit 5 is set with `ien[5]`. The flags show in bits 4 and 5 whatever their enable, and they never change bit 0.
- R11: Every change reaches `iir` and `irq` at the first rising edge after the input cycle. When the top source goes away, the next source is shown on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien | input | 6 | Source enables (layout above) |
| rx_trig | input | 2 | Receive trigger-level select |
| rx_count | input | CNT_W | Characters held in the receive FIFO |
| line_err | input | 4 | Overrun, parity, framing, break flags |
| rx_timeout | input | 1 | Character timeout condition |
| thr_empty | input | 1 | Transmit holding register empty status |
| thr_wr | input | 1 | Holding register write strobe |
| modem_delta | input | 1 | Modem status change condition |
| xoff_seen | input | 1 | XOFF character received pulse |
| cts_rise | input | 1 | CTS rising-edge pulse |
| rts_rise | input | 1 | RTS rising-edge pulse |
| iir_rd | input | 1 | Identification register read strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which its stimulus is applied. This covers level conditions, pulse-set flags, read and write clears, and the next-ranked source appearing once the top one is removed. The driver therefore applies each stimulus at a falling edge and pushes the expected byte and request. The monitor pops and compares one nanosecond after the following rising edge. Read-clear cases are sequenced so that the code visible during the read cycle is known, which exercises the rule that a read clears transmit-empty only when transmit-empty was the code shown.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ID_MODEM  = 3'd0,
    ID_THRE   = 3'd1,
    ID_RXDATA = 3'd2,
    ID_LINE   = 3'd3,
    ID_TMO    = 3'd6
  } id_e;

  localparam int NSRC = 5;
  // rank order, index 0 is highest
  localparam id_e RANK [NSRC] = '{ID_LINE, ID_RXDATA, ID_TMO, ID_THRE, ID_MODEM};

  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_XOFF  = 4;
  localparam int EN_EDGE  = 5;
  localparam int EN_W     = 6;
endpackage

// File: rtl/uart_irq_rxlvl.sv
module uart_irq_rxlvl #(
  parameter int CNT_W = 5,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14
) (
  input  logic [1:0]       rx_trig,
  input  logic [CNT_W-1:0] rx_count,
  output logic             at_level
);
  logic [CNT_W-1:0] thresh;

  always_comb begin
    case (rx_trig)
      2'd0:    thresh = CNT_W'(TRIG0);
      2'd1:    thresh = CNT_W'(TRIG1);
      2'd2:    thresh = CNT_W'(TRIG2);
      default: thresh = CNT_W'(TRIG3);
    endcase
  end

  assign at_level = (rx_count >= thresh);
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags (
  input  logic clk,
  input  logic rst,
  input  logic thr_empty,
  input  logic thr_wr,
  input  logic thre_rd_clr,
  input  logic xoff_seen,
  input  logic edge_seen,
  input  logic iir_rd,
  output logic thre_nxt,
  output logic xoff_nxt,
  output logic edge_nxt
);
  logic empty_q, thre_q, xoff_q, edge_q;
  logic empty_rise;

  assign empty_rise = thr_empty & ~empty_q;
  assign thre_nxt   = thr_empty & ~thr_wr & (empty_rise | (thre_q & ~thre_rd_clr));
  assign xoff_nxt   = xoff_seen | (xoff_q & ~iir_rd);
  assign edge_nxt   = edge_seen | (edge_q & ~iir_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b0;
      thre_q  <= 1'b0;
      xoff_q  <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      empty_q <= thr_empty;
      thre_q  <= thre_nxt;
      xoff_q  <= xoff_nxt;
      edge_q  <= edge_nxt;
    end
  end

  // R8: a received XOFF is always recorded
  p_xoff_set_r8: assert property (@(posedge clk) disable iff (rst)
    xoff_seen |=> xoff_q);
  // R6: a holding-register write drops the transmit-empty event
  p_thr_wr_clr_r6: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> !thre_q);
  // R9: an edge pulse is recorded
  p_edge_set_r9: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> edge_q);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic            any,
  output id_e             code
);
  always_comb begin
    any  = |req;
    code = ID_MODEM;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) code = RANK[i];
    end
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int IIR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EN_W-1:0]   ien,
  input  logic [1:0]        rx_trig,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [3:0]        line_err,
  input  logic              rx_timeout,
  input  logic              thr_empty,
  input  logic              thr_wr,
  input  logic              modem_delta,
  input  logic              xoff_seen,
  input  logic              cts_rise,
  input  logic              rts_rise,
  input  logic              iir_rd,
  output logic [IIR_W-1:0]  iir,
  output logic              irq
);
  localparam logic [IIR_W-1:0] IIR_IDLE = IIR_W'(1);

  logic [IIR_W-1:0] iir_q;
  logic             irq_q;
  logic             rx_lvl, thre_rd_clr;
  logic             thre_nxt, xoff_nxt, edge_nxt;
  logic [NSRC-1:0]  req;
  logic             any;
  id_e              code;

  uart_irq_rxlvl #(.CNT_W(CNT_W)) u_rxlvl (
    .rx_trig (rx_trig),
    .rx_count(rx_count),
    .at_level(rx_lvl)
  );

  assign thre_rd_clr = iir_rd & ~iir_q[0] & (iir_q[3:1] == 3'(ID_THRE));

  uart_irq_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .thr_empty  (thr_empty),
    .thr_wr     (thr_wr),
    .thre_rd_clr(thre_rd_clr),
    .xoff_seen  (xoff_seen),
    .edge_seen  (cts_rise | rts_rise),
    .iir_rd     (iir_rd),
    .thre_nxt   (thre_nxt),
    .xoff_nxt   (xoff_nxt),
    .edge_nxt   (edge_nxt)
  );

  // index order follows RANK
  assign req[0] = ien[EN_LINE]  & (|line_err);
  assign req[1] = ien[EN_RX]    & rx_lvl;
  assign req[2] = ien[EN_RX]    & rx_timeout;
  assign req[3] = ien[EN_THRE]  & thre_nxt;
  assign req[4] = ien[EN_MODEM] & modem_delta;

  uart_irq_prio u_prio (
    .req (req),
    .any (any),
    .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= IIR_IDLE;
      irq_q <= 1'b0;
    end else begin
      iir_q <= {(IIR_W-6)'(0), edge_nxt, xoff_nxt, code, ~any};
      irq_q <= any | (ien[EN_XOFF] & xoff_nxt) | (ien[EN_EDGE] & edge_nxt);
    end
  end

  assign iir = iir_q;
  assign irq = irq_q;

  // R2: idle byte carries a zero code
  p_idle_code_r2: assert property (@(posedge clk) disable iff (rst)
    iir_q[0] |-> (iir_q[3:1] == 3'd0));
  // R10: a shown code always raises the request
  p_pend_irq_r10: assert property (@(posedge clk) disable iff (rst)
    !iir_q[0] |-> irq_q);
  // R3: enabled line error is shown as top source next cycle
  p_line_top_r3: assert property (@(posedge clk) disable iff (rst)
    (ien[EN_LINE] && (|line_err)) |=> (iir_q[3:0] == 4'b0110));
  // R2: only the five defined codes ever appear
  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    (iir_q[3:1] != 3'd4) && (iir_q[3:1] != 3'd5) && (iir_q[3:1] != 3'd7));
endmodule

// File: tb/uart_irq_id_bench.sv
`timescale 1ns/100ps
module uart_irq_id_bench;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [5:0]       ien = 6'b111111;
  logic [1:0]       rx_trig = 2'd0;
  logic [CNT_W-1:0] rx_count = '0;
  logic [3:0]       line_err = 4'd0;
  logic             rx_timeout = 1'b0, thr_empty = 1'b0, thr_wr = 1'b0;
  logic             modem_delta = 1'b0, xoff_seen = 1'b0;
  logic             cts_rise = 1'b0, rts_rise = 1'b0, iir_rd = 1'b0;
  logic [7:0]       iir;
  logic             irq;

  typedef struct {
    string      tag;
    logic [7:0] e_iir;
    logic       e_irq;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_id u_uart_irq_id (
    .clk(clk), .rst(rst), .ien(ien), .rx_trig(rx_trig), .rx_count(rx_count),
    .line_err(line_err), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
    .thr_wr(thr_wr), .modem_delta(modem_delta), .xoff_seen(xoff_seen),
    .cts_rise(cts_rise), .rts_rise(rts_rise), .iir_rd(iir_rd),
    .iir(iir), .irq(irq)
  );

  // driver: push expectation for the edge that follows, then move on
  task automatic cyc(input string tag, input logic [7:0] e_iir, input logic e_irq);
    item_t it;
    it.tag = tag; it.e_iir = e_iir; it.e_irq = e_irq;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (iir !== it.e_iir || irq !== it.e_irq) begin
          errors++;
          $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
                   it.tag, iir, irq, it.e_iir, it.e_irq);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc("R1 reset", 8'h01, 1'b0);
    cyc("R1 reset hold", 8'h01, 1'b0);
    rst = 1'b0;
    cyc("R2 idle", 8'h01, 1'b0);

    // ranking
    line_err = 4'b0010; rx_count = 5'd1; rx_timeout = 1'b1; modem_delta = 1'b1;
    cyc("R3 line top", 8'h06, 1'b1);
    line_err = 4'd0;
    cyc("R11 rxdata next", 8'h04, 1'b1);
    rx_count = 5'd0;
    cyc("R5 timeout", 8'h0C, 1'b1);
    rx_timeout = 1'b0;
    cyc("R7 modem", 8'h00, 1'b1);
    modem_delta = 1'b0;
    cyc("R2 back idle", 8'h01, 1'b0);
    line_err = 4'b1000;
    cyc("R3 break", 8'h06, 1'b1);
    line_err = 4'd0;

    // trigger levels
    rx_trig = 2'd1; rx_count = 5'd3;  cyc("R4 lvl1 below", 8'h01, 1'b0);
    rx_count = 5'd4;                   cyc("R4 lvl1 at", 8'h04, 1'b1);
    rx_trig = 2'd2; rx_count = 5'd7;  cyc("R4 lvl2 below", 8'h01, 1'b0);
    rx_count = 5'd8;                   cyc("R4 lvl2 at", 8'h04, 1'b1);
    rx_trig = 2'd3; rx_count = 5'd13; cyc("R4 lvl3 below", 8'h01, 1'b0);
    rx_count = 5'd14;                  cyc("R4 lvl3 at", 8'h04, 1'b1);
    rx_count = 5'd16;                  cyc("R4 lvl3 above", 8'h04, 1'b1);
    rx_trig = 2'd0; rx_count = 5'd0;

    // shared receive enable
    ien[0] = 1'b0; rx_count = 5'd5; rx_timeout = 1'b1;
    cyc("R5 rx enable off", 8'h01, 1'b0);
    ien[0] = 1'b1; rx_count = 5'd0;
    cyc("R5 timeout on", 8'h0C, 1'b1);
    rx_timeout = 1'b0;
    cyc("R2 idle", 8'h01, 1'b0);

    // transmit empty
    thr_empty = 1'b1; cyc("R6 rise", 8'h02, 1'b1);
    cyc("R6 hold", 8'h02, 1'b1);
    iir_rd = 1'b1; cyc("R6 read clears", 8'h01, 1'b0);
    iir_rd = 1'b0; cyc("R6 stays clear", 8'h01, 1'b0);
    thr_empty = 1'b0; cyc("R6 low", 8'h01, 1'b0);
    thr_empty = 1'b1; cyc("R6 rise again", 8'h02, 1'b1);
    thr_wr = 1'b1; cyc("R6 write clears", 8'h01, 1'b0);
    thr_wr = 1'b0; thr_empty = 1'b0; cyc("R6 idle", 8'h01, 1'b0);
    thr_empty = 1'b1; cyc("R6 rise 3", 8'h02, 1'b1);
    line_err = 4'b0001; cyc("R3 over thre", 8'h06, 1'b1);
    iir_rd = 1'b1; cyc("R6 read other code", 8'h06, 1'b1);
    iir_rd = 1'b0; line_err = 4'd0; cyc("R6 still pending", 8'h02, 1'b1);
    thr_empty = 1'b0; cyc("R6 status fall", 8'h01, 1'b0);
    ien[1] = 1'b0; thr_empty = 1'b1; cyc("R6 masked", 8'h01, 1'b0);
    thr_wr = 1'b1; cyc("R6 masked clear", 8'h01, 1'b0);
    thr_wr = 1'b0; ien[1] = 1'b1; cyc("R6 cleared before unmask", 8'h01, 1'b0);
    thr_empty = 1'b0;

    // XOFF flag
    xoff_seen = 1'b1; cyc("R8 set", 8'h11, 1'b1);
    xoff_seen = 1'b0; cyc("R8 hold", 8'h11, 1'b1);
    iir_rd = 1'b1; cyc("R8 read clears", 8'h01, 1'b0);
    xoff_seen = 1'b1; cyc("R8 set wins", 8'h11, 1'b1);
    xoff_seen = 1'b0; cyc("R8 read clears 2", 8'h01, 1'b0);
    iir_rd = 1'b0;
    ien[4] = 1'b0; xoff_seen = 1'b1; cyc("R10 xoff masked", 8'h11, 1'b0);
    xoff_seen = 1'b0; ien[4] = 1'b1; cyc("R10 xoff unmasked", 8'h11, 1'b1);
    iir_rd = 1'b1; cyc("R8 clear", 8'h01, 1'b0);
    iir_rd = 1'b0;

    // flow edge flag
    cts_rise = 1'b1; cyc("R9 cts", 8'h21, 1'b1);
    cts_rise = 1'b0; iir_rd = 1'b1; cyc("R9 read clears", 8'h01, 1'b0);
    iir_rd = 1'b0; rts_rise = 1'b1; cyc("R9 rts", 8'h21, 1'b1);
    rts_rise = 1'b0; ien[5] = 1'b0; cyc("R10 edge masked", 8'h21, 1'b0);
    modem_delta = 1'b1; cyc("R10 flag with code", 8'h20, 1'b1);
    modem_delta = 1'b0; iir_rd = 1'b1; ien[5] = 1'b1; cyc("R9 clear", 8'h01, 1'b0);
    iir_rd = 1'b0;

    // line enable
    ien[2] = 1'b0; line_err = 4'b0100; cyc("R10 line masked", 8'h01, 1'b0);
    ien[2] = 1'b1; cyc("R3 framing", 8'h06, 1'b1);
    line_err = 4'd0; cyc("R11 drop", 8'h01, 1'b0);

    // reset mid-activity
    modem_delta = 1'b1; cyc("R7 modem", 8'h00, 1'b1);
    rst = 1'b1; cyc("R1 reset again", 8'h01, 1'b0);
    rst = 1'b0; modem_delta = 1'b0; cyc("R2 after reset", 8'h01, 1'b0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d results never compared, expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule